// File: doc/BRIEF.md
# Descriptor-Chain Transmit DMA

This block is the transmit engine of one serial channel. Software builds a linked list of four-word descriptors in memory, points the engine at the first one and sets a demand bit in the command register. The engine then walks the list. For each descriptor it owns, it reads the buffer and sends it out as a byte stream on a valid/ready port. It then hands the descriptor back to software by writing it with the byte-count field kept, the low half of the size word cleared and the owner bit cleared.

The walk ends in one of two ways. If the engine fetches a descriptor that software still owns, it stops and leaves the demand bit set. If it reaches a null next pointer, it stops and clears the demand bit. Either way it raises a one-cycle event toward the interrupt cause logic. Memory is reached through a 32-bit word master port that has at most one request in flight. The channel's register window is decoded by a 12-bit offset, and the system-level decoder maps that window into the channel's address range.

A descriptor is four words, in this order: the size word (byte count in bits 31:16), the command/status word (owner in bit 31, interrupt enable in bit 23, first buffer in bit 17, last buffer in bit 16), the next-descriptor pointer and the buffer pointer.

Top module: `tdma_tx_top`

## Requirements
- R1: After reset the command, current TX pointer, first TX pointer and RX pointer registers read zero, and tx_valid, mem_req and txbuf_evt are low.
- R2: Register offsets are: command 0x008, RX pointer 0x810, current TX pointer 0xC10, first TX pointer 0xC14. Each reads back what was written. Any other offset reads zero, and writes to it have no effect.
- R3: Writing the command register with bit 23 set while the engine is idle starts a walk at the current TX pointer. A command write with bit 23 clear starts nothing. A write made while a walk is running starts nothing.
- R4: Each descriptor is read as four words at offsets 0, 4, 8 and 12. Bits 3:0 of every descriptor pointer are ignored. The current TX pointer register takes each descriptor's address as that descriptor is fetched.
- R5: An owned descriptor sends exactly the byte count from size-word bits 31:16. Bytes come from the buffer (pointer bits 1:0 ignored), least significant byte of each word first, and a partial last word is allowed. tx_data is held while tx_valid is high and tx_ready is low.
- R6: After its bytes are sent, a descriptor gets two writes: its size word with bits 15:0 cleared goes to offset 0, then its command word with bit 31 cleared goes to offset 4. A byte count of zero sends no bytes but still writes back.
- R7: A fetched descriptor whose bit 31 is clear stops the walk. It sends no bytes and gets no write-back, txbuf_evt pulses, and command bit 23 stays set.
- R8: A walk that reaches a zero next pointer, or starts from a zero pointer, pulses txbuf_evt and clears command bit 23. A zero start pointer makes no memory request.
- R9: mem_req and mem_addr stay stable until mem_ack. A memory request and tx_valid are never high together.
- R10: A command write in the same cycle the engine clears the demand bit keeps the written value. Writes to the current TX pointer during a walk are ignored.
- R11: txbuf_evt is high for exactly one cycle per finished walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset inside the channel window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Byte value |
| tx_ready | input | 1 | Sink takes the byte |
| txbuf_evt | output | 1 | Walk-finished event to the cause logic |

## Verification
The command register has two writers: software, and the engine clearing the demand bit at the end of a null-terminated walk. Both can act in the same cycle. The bench provokes this by starting a walk from a zero pointer and, in the very next cycle, writing the command register again with a different value. That second write lands exactly when the engine clears the demand bit. The bench judges the result from the command value read back, which must equal the second write, and from the event count, which must be one.

// File: rtl/tdma_pkg.sv
`timescale 1ns/1ps
package tdma_pkg;
   typedef enum logic [2:0] {
      W_IDLE, W_NEXT, W_FETCH, W_CHECK, W_RDBUF, W_SEND, W_WBSIZE, W_WBCMD
   } walk_st_t;

   localparam int DESC_WORDS = 4;
   localparam int SLOT_SIZE  = 0;
   localparam int SLOT_CMD   = 1;
   localparam int SLOT_NEXT  = 2;
   localparam int SLOT_BUF   = 3;
endpackage

// File: rtl/tdma_tx_regs.sv
`timescale 1ns/1ps
module tdma_tx_regs #(
   parameter int WORD_W = 32,
   parameter int REG_AW = 12,
   parameter logic [REG_AW-1:0] OFS_CMD   = 12'h008,
   parameter logic [REG_AW-1:0] OFS_RXP   = 12'h810,
   parameter logic [REG_AW-1:0] OFS_CURTX = 12'hC10,
   parameter logic [REG_AW-1:0] OFS_FSTTX = 12'hC14,
   parameter int DEMAND_BIT = 23
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic              busy,
   input  logic              ptr_load,
   input  logic [WORD_W-1:0] ptr_val,
   input  logic              clr_demand,
   output logic              start,
   output logic [WORD_W-1:0] cur_ptr
);
   logic [WORD_W-1:0] cmd_q, rxp_q, fst_q;
   logic hit_cmd, hit_cur, hit_rxp, hit_fst;

   assign hit_cmd = reg_wr && (reg_addr == OFS_CMD);
   assign hit_cur = reg_wr && (reg_addr == OFS_CURTX);
   assign hit_rxp = reg_wr && (reg_addr == OFS_RXP);
   assign hit_fst = reg_wr && (reg_addr == OFS_FSTTX);

   // a demand only launches a walk from idle
   assign start = hit_cmd && reg_wdata[DEMAND_BIT] && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         cur_ptr <= '0;
         rxp_q   <= '0;
         fst_q   <= '0;
      end else begin
         // software write has priority over the engine's demand clear
         if (hit_cmd)         cmd_q <= reg_wdata;
         else if (clr_demand) cmd_q[DEMAND_BIT] <= 1'b0;
         if (ptr_load)                cur_ptr <= ptr_val;
         else if (hit_cur && !busy)   cur_ptr <= reg_wdata;
         if (hit_rxp) rxp_q <= reg_wdata;
         if (hit_fst) fst_q <= reg_wdata;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == OFS_CMD)   reg_rdata = cmd_q;
      if (reg_addr == OFS_CURTX) reg_rdata = cur_ptr;
      if (reg_addr == OFS_RXP)   reg_rdata = rxp_q;
      if (reg_addr == OFS_FSTTX) reg_rdata = fst_q;
   end
endmodule

// File: rtl/tdma_lane_pick.sv
`timescale 1ns/1ps
module tdma_lane_pick #(
   parameter int WORD_W = 32,
   localparam int LANES  = WORD_W / 8,
   localparam int LANE_W = $clog2(LANES)
) (
   input  logic [WORD_W-1:0] word,
   input  logic [LANE_W-1:0] lane,
   output logic [7:0]        byte_out
);
   logic [7:0] lanes_a [LANES];
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes_a[g] = word[8*g +: 8];
   end
   assign byte_out = lanes_a[lane];
endmodule

// File: rtl/tdma_tx_walker.sv
`timescale 1ns/1ps
module tdma_tx_walker
   import tdma_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int CNT_W     = 16,
   parameter int OWNER_BIT = 31,
   parameter int ALIGN_LSB = 4,
   localparam int LANES  = WORD_W / 8,
   localparam int LANE_W = $clog2(LANES),
   localparam int IDX_W  = $clog2(DESC_WORDS),
   localparam int LOW_W  = WORD_W - CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] start_ptr,
   output logic              busy,
   output logic              ptr_load,
   output logic [WORD_W-1:0] ptr_val,
   output logic              clr_demand,
   output logic              evt,
   output logic              mem_req,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [WORD_W-1:0] word_q,
   output logic [LANE_W-1:0] lane_q
);
   localparam logic [WORD_W-1:0] DESC_MASK = ~((WORD_W'(1) << ALIGN_LSB) - WORD_W'(1));
   localparam logic [WORD_W-1:0] WORD_MASK = ~((WORD_W'(1) << LANE_W) - WORD_W'(1));
   localparam logic [WORD_W-1:0] OWN_MASK  = WORD_W'(1) << OWNER_BIT;

   walk_st_t          st;
   logic [IDX_W-1:0]  idx;
   logic [WORD_W-1:0] walk_addr, baddr, cmd_q, next_q, buf_q;
   logic [CNT_W-1:0]  cnt_q, remain;
   logic              null_end, unowned;

   assign null_end = (st == W_NEXT) && (walk_addr == '0);
   assign unowned  = (st == W_CHECK) && !cmd_q[OWNER_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= W_IDLE;
         idx <= '0;
         walk_addr <= '0;
         baddr <= '0;
         cmd_q <= '0;
         next_q <= '0;
         buf_q <= '0;
         cnt_q <= '0;
         remain <= '0;
         word_q <= '0;
         lane_q <= '0;
      end else begin
         unique case (st)
            W_IDLE: if (start) begin
               walk_addr <= start_ptr & DESC_MASK;
               st <= W_NEXT;
            end
            W_NEXT: begin
               idx <= '0;
               st <= (walk_addr == '0) ? W_IDLE : W_FETCH;
            end
            W_FETCH: if (mem_ack) begin
               unique case (idx)
                  IDX_W'(SLOT_SIZE): cnt_q  <= mem_rdata[WORD_W-1 -: CNT_W];
                  IDX_W'(SLOT_CMD):  cmd_q  <= mem_rdata;
                  IDX_W'(SLOT_NEXT): next_q <= mem_rdata & DESC_MASK;
                  default:           buf_q  <= mem_rdata & WORD_MASK;
               endcase
               idx <= idx + IDX_W'(1);
               if (idx == IDX_W'(DESC_WORDS-1)) st <= W_CHECK;
            end
            W_CHECK: begin
               remain <= cnt_q;
               baddr  <= buf_q;
               if (!cmd_q[OWNER_BIT])  st <= W_IDLE;
               else if (cnt_q == '0)   st <= W_WBSIZE;
               else                    st <= W_RDBUF;
            end
            W_RDBUF: if (mem_ack) begin
               word_q <= mem_rdata;
               lane_q <= '0;
               st <= W_SEND;
            end
            W_SEND: if (tx_ready) begin
               remain <= remain - CNT_W'(1);
               lane_q <= lane_q + LANE_W'(1);
               if (remain == CNT_W'(1)) st <= W_WBSIZE;
               else if (lane_q == LANE_W'(LANES-1)) begin
                  baddr <= baddr + WORD_W'(LANES);
                  st <= W_RDBUF;
               end
            end
            W_WBSIZE: if (mem_ack) st <= W_WBCMD;
            W_WBCMD: if (mem_ack) begin
               walk_addr <= next_q;
               st <= W_NEXT;
            end
            default: st <= W_IDLE;
         endcase
      end
   end

   assign busy       = (st != W_IDLE);
   assign ptr_load   = (st == W_NEXT) && (walk_addr != '0);
   assign ptr_val    = walk_addr;
   assign clr_demand = null_end;
   assign evt        = null_end || unowned;
   assign tx_valid   = (st == W_SEND);

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = walk_addr;
      mem_wdata = '0;
      unique case (st)
         W_FETCH: begin
            mem_req  = 1'b1;
            mem_addr = walk_addr + (WORD_W'(idx) << LANE_W);
         end
         W_RDBUF: begin
            mem_req  = 1'b1;
            mem_addr = baddr;
         end
         W_WBSIZE: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_wdata = {cnt_q, {LOW_W{1'b0}}};
         end
         W_WBCMD: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = walk_addr + WORD_W'(LANES);
            mem_wdata = cmd_q & ~OWN_MASK;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/tdma_tx_top.sv
`timescale 1ns/1ps
module tdma_tx_top #(
   parameter int WORD_W     = 32,
   parameter int REG_AW     = 12,
   parameter int CNT_W      = 16,
   parameter int OWNER_BIT  = 31,
   parameter int DEMAND_BIT = 23,
   parameter int ALIGN_LSB  = 4,
   localparam int LANES  = WORD_W / 8,
   localparam int LANE_W = $clog2(LANES),
   localparam int LOW_W  = WORD_W - CNT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [WORD_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   input  logic              tx_ready,
   output logic              txbuf_evt
);
   if (WORD_W != 32) begin : g_bad_word
      $error("tdma_tx_top: WORD_W must be 32");
   end
   if (CNT_W < 1 || CNT_W > WORD_W / 2) begin : g_bad_cnt
      $error("tdma_tx_top: CNT_W out of range");
   end
   if (OWNER_BIT >= WORD_W || DEMAND_BIT >= WORD_W) begin : g_bad_bit
      $error("tdma_tx_top: control bit outside the word");
   end
   if (ALIGN_LSB != LANE_W + 2) begin : g_bad_align
      $error("tdma_tx_top: descriptor alignment must cover four words");
   end

   logic              busy, ptr_load, clr_demand, start;
   logic [WORD_W-1:0] ptr_val, cur_ptr, word_q;
   logic [LANE_W-1:0] lane_q;

   tdma_tx_regs #(
      .WORD_W(WORD_W), .REG_AW(REG_AW), .DEMAND_BIT(DEMAND_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
      .ptr_load(ptr_load), .ptr_val(ptr_val), .clr_demand(clr_demand),
      .start(start), .cur_ptr(cur_ptr)
   );

   tdma_tx_walker #(
      .WORD_W(WORD_W), .CNT_W(CNT_W), .OWNER_BIT(OWNER_BIT), .ALIGN_LSB(ALIGN_LSB)
   ) u_walk (
      .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(cur_ptr),
      .busy(busy), .ptr_load(ptr_load), .ptr_val(ptr_val),
      .clr_demand(clr_demand), .evt(txbuf_evt), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .word_q(word_q), .lane_q(lane_q)
   );

   tdma_lane_pick #(.WORD_W(WORD_W)) u_pick (
      .word(word_q), .lane(lane_q), .byte_out(tx_data)
   );
endmodule

// File: rtl/tdma_tx_chk.sv
`timescale 1ns/1ps
module tdma_tx_chk #(
   parameter int LOW_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_req,
   input logic             mem_we,
   input logic             mem_ack,
   input logic [1:0]       slot,
   input logic             wb_own,
   input logic [LOW_W-1:0] wb_low,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic [7:0]       tx_data,
   input logic             txbuf_evt
);
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(slot) && $stable(mem_we));

   p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && tx_valid));

   p_byte_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

   p_own_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && slot == 2'd1 |-> !wb_own);

   p_low_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && slot == 2'd0 |-> wb_low == '0);

   p_wb_slots_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> slot[1] == 1'b0);

   p_evt_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      txbuf_evt |=> !txbuf_evt);
endmodule

bind tdma_tx_top tdma_tx_chk #(.LOW_W(LOW_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
   .mem_ack(mem_ack), .slot(mem_addr[LANE_W +: 2]),
   .wb_own(mem_wdata[OWNER_BIT]), .wb_low(mem_wdata[LOW_W-1:0]),
   .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
   .txbuf_evt(txbuf_evt)
);

// File: tb/tdma_tx_top_test.sv
`timescale 1ns/1ps
module tdma_tx_top_test;
   localparam logic [11:0] A_CMD = 12'h008, A_RXP = 12'h810,
                           A_CUR = 12'hC10, A_FST = 12'hC14;
   localparam logic [31:0] DEMAND = 32'h0080_0000;
   // {owner, byte count}
   localparam logic [16:0] CASES [8] = '{17'h10000, 17'h10001, 17'h10003,
      17'h10004, 17'h10005, 17'h10008, 17'h10009, 17'h00006};

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        tx_valid, tx_ready = 1'b1, txbuf_evt;
   logic [7:0]  tx_data;

   logic [31:0] mem [0:1023];
   logic [7:0]  cap [0:63];
   int ncap = 0, nevt = 0, nreq = 0, nclash = 0, cyc = 0;
   int checks = 0, errors = 0;
   bit stall = 1'b0;

   tdma_tx_top uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
      .tx_data(tx_data), .tx_ready(tx_ready), .txbuf_evt(txbuf_evt)
   );

   // memory slave: acknowledges one cycle after a request is seen
   always @(posedge clk) begin
      if (!rst_n) mem_ack <= 1'b0;
      else begin
         mem_ack   <= mem_req && !mem_ack;
         mem_rdata <= mem[mem_addr[11:2]];
         if (mem_req && mem_we && mem_ack) mem[mem_addr[11:2]] <= mem_wdata;
      end
   end

   always @(negedge clk) begin
      cyc++;
      tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (tx_valid && tx_ready && ncap < 64) begin
         cap[ncap] = tx_data;
         ncap++;
      end
      if (txbuf_evt) nevt++;
      if (mem_req) nreq++;
      if (mem_req && tx_valid) nclash++;
      if (cyc == 100000) begin
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [7:0] fb(input int x);
      return 8'((x * 7 + 1) & 255) ^ 8'h5A;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic put_desc(input int a, input logic [31:0] sz, cm, nx, bf);
      mem[a >> 2]       <= sz;
      mem[(a >> 2) + 1] <= cm;
      mem[(a >> 2) + 2] <= nx;
      mem[(a >> 2) + 3] <= bf;
   endtask

   task automatic fill_buf(input int base, input int words);
      for (int i = 0; i < words; i++) begin
         int b;
         b = base + 4 * i;
         mem[b >> 2] <= {fb(b + 3), fb(b + 2), fb(b + 1), fb(b)};
      end
   endtask

   task automatic clear_counts();
      @(negedge clk);
      ncap = 0; nevt = 0; nreq = 0; nclash = 0;
   endtask

   task automatic wait_evt(input int lim);
      for (int i = 0; i < lim && nevt == 0; i++) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   logic [31:0] rv;
   int bad;

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CMD, rv); chk("R1 command after reset", rv, 0);
      rd(A_CUR, rv); chk("R1 current TX pointer after reset", rv, 0);
      rd(A_FST, rv); chk("R1 first TX pointer after reset", rv, 0);
      rd(A_RXP, rv); chk("R1 RX pointer after reset", rv, 0);
      chk("R1 outputs idle", {29'd0, tx_valid, mem_req, txbuf_evt}, 0);

      // R2 register map
      wr(A_FST, 32'h1234_5678); rd(A_FST, rv); chk("R2 first TX pointer", rv, 32'h1234_5678);
      wr(A_RXP, 32'h0000_ABC0); rd(A_RXP, rv); chk("R2 RX pointer", rv, 32'h0000_ABC0);
      wr(A_CUR, 32'h0000_0ABC); rd(A_CUR, rv); chk("R2 current TX pointer", rv, 32'h0000_0ABC);
      wr(12'h004, 32'hFFFF_FFFF); rd(12'h004, rv); chk("R2 unmapped offset", rv, 0);
      rd(A_FST, rv); chk("R2 unmapped write no effect", rv, 32'h1234_5678);

      // R3 command write without demand starts nothing
      put_desc(32'h100, {16'd4, 16'h0}, 32'h8000_0000, 0, 32'h400);
      fill_buf(32'h400, 1);
      wr(A_CUR, 32'h100);
      clear_counts();
      wr(A_CMD, 32'h0000_0001);
      repeat (40) @(negedge clk);
      chk("R3 no walk without demand", {ncap[15:0], nevt[7:0], nreq[7:0]}, 0);

      // table of single-descriptor cases (R5 R6 R7 R8 R4 R11)
      for (int k = 0; k < 8; k++) begin
         logic [15:0] cnt;
         logic        own;
         int          expn;
         cnt = CASES[k][15:0];
         own = CASES[k][16];
         put_desc(32'h100, {cnt, 16'hBEEF}, 32'h0083_1234 | {own, 31'd0}, 0, 32'h400);
         fill_buf(32'h400, 4);
         clear_counts();
         wr(A_CUR, 32'h100);
         wr(A_CMD, DEMAND);
         wait_evt(400);
         expn = own ? int'(cnt) : 0;
         chk("R5 byte count", ncap, expn);
         bad = 0;
         for (int i = 0; i < expn; i++) if (cap[i] !== fb(32'h400 + i)) bad++;
         chk("R5 byte values in order", bad, 0);
         chk(own ? "R6 size word written back" : "R7 size word untouched",
             mem[32'h100 >> 2], own ? {cnt, 16'h0} : {cnt, 16'hBEEF});
         chk(own ? "R6 owner cleared" : "R7 command word untouched",
             mem[(32'h100 >> 2) + 1], 32'h0083_1234);
         rd(A_CMD, rv);
         chk(own ? "R8 demand cleared at null end" : "R7 demand kept", rv, own ? 0 : DEMAND);
         rd(A_CUR, rv); chk("R4 current pointer follows fetch", rv, 32'h100);
         chk("R11 single event cycle", nevt, 1);
      end

      // chain with back-pressure, ends on a software-owned descriptor
      put_desc(32'h100, {16'd2, 16'h1111}, 32'h8083_1234, 32'h140, 32'h400);
      put_desc(32'h140, {16'd6, 16'h2222}, 32'h8080_0000, 32'h188, 32'h500);
      put_desc(32'h180, {16'd3, 16'h3333}, 32'h0000_0000, 32'h1C0, 32'h600);
      fill_buf(32'h400, 1);
      fill_buf(32'h500, 2);
      stall = 1'b1;
      clear_counts();
      wr(A_CUR, 32'h105);
      wr(A_CMD, DEMAND);
      repeat (6) @(negedge clk);
      wr(A_CUR, 32'h700);
      wr(A_CMD, DEMAND | 32'h2);
      wait_evt(2000);
      repeat (30) @(negedge clk);
      stall = 1'b0;
      chk("R5 chain byte count", ncap, 8);
      bad = 0;
      for (int i = 0; i < 8; i++)
         if (cap[i] !== (i < 2 ? fb(32'h400 + i) : fb(32'h500 + i - 2))) bad++;
      chk("R5 chain bytes under back-pressure", bad, 0);
      chk("R6 first descriptor size", mem[32'h100 >> 2], {16'd2, 16'h0});
      chk("R6 second descriptor command", mem[(32'h140 >> 2) + 1], 32'h0080_0000);
      chk("R7 owned-by-software descriptor untouched", mem[32'h180 >> 2], {16'd3, 16'h3333});
      rd(A_CUR, rv); chk("R4 R10 pointer at stop descriptor", rv, 32'h180);
      rd(A_CMD, rv); chk("R7 demand kept after owner stop", rv, DEMAND | 32'h2);
      chk("R3 busy demand write starts nothing", nevt, 1);
      chk("R9 request never with tx_valid", nclash, 0);

      // R8 zero start pointer
      wr(A_CUR, 32'h0);
      clear_counts();
      wr(A_CMD, DEMAND);
      wait_evt(100);
      rd(A_CMD, rv); chk("R8 demand cleared for null start", rv, 0);
      chk("R8 no memory traffic for null start", nreq, 0);
      chk("R11 null start one event", nevt, 1);

      // R10 software write collides with the demand clear
      clear_counts();
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = DEMAND;
      @(negedge clk);
      reg_wdata = DEMAND | 32'h5;
      @(negedge clk);
      reg_wr = 1'b0;
      repeat (6) @(negedge clk);
      rd(A_CMD, rv); chk("R10 software write wins over clear", rv, DEMAND | 32'h5);
      chk("R10 collision single event", nevt, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule